// File: doc/BRIEF.md
# Flash Write-Engine Control Register with Unlock Guard

This block is the single control and status register that software uses to steer an on-chip flash write engine. Out of reset the register is hidden: reads at its address return zero and writes to it only feed a guard state machine. Software opens it with a fixed two-write key sequence. The first write puts the key value at the register address. The second write puts the same key value at the address equal to the key. Any other write in between sends the guard back to its idle state.

Once the register is open, software loads a setup word. This word picks program or erase, one or two words per pulse, a bank and a pulse-width code. Loading the setup word never starts anything. It only arms the engine. The pulse is launched by the next write that falls into the flash array address space, and that write produces a one-cycle start strobe for the external pulse timer. The timer reports back on a busy input. While busy is high, a supply-low indication sets a sticky fault bit. Writing zero to the register clears every setting, hides the register again and re-enables normal array reads.

Top module: `flashctl_top`

## Requirements
- R1: After reset the register is hidden (a read at the register address gives 0), array reads are enabled, the start strobe is 0 and every mode output is 0.
- R2: The register opens only after a write of the key (default 1000h) to the register address (default 7FFEh), followed by a write of the key to address 1000h. Once open, array reads are disabled and the register reads back.
- R3: Any write that breaks the key pair (a different address or different data for either step) returns the guard to idle, and the register stays hidden.
- R4: Control fields sit at these bit positions: write enable 0, erase enable 1, pulse code 6:5, two-word select 7, bank 9:8. Other written bits read back as 0. The mode outputs are: program = write enable with erase clear; erase = both set; plus the two-word select, bank and pulse code fields.
- R5: Status bits read live: busy at bit 2 follows the busy input, supply-valid at bit 4 follows the supply input.
- R6: Loading the setup word gives no start. With write enable set, each later write into the array space (address bit 15 clear) gives a start strobe one cycle after the write edge.
- R7: A start write that arrives while busy is 1 produces no strobe.
- R8: The fault bit (bit 3) sets on any clock where busy is 1 and the supply input is 0. It stays set until the next accepted start or until the register is cleared.
- R9: Writing zero to the open register clears all control bits and the fault bit, hides the register and re-enables array reads. Later array writes give no start.
- R10: When write enable is clear in the setup word, array writes produce no start.
- R11: A write to the register address itself never produces a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 16 | Word address of the access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read data at the register address, 0 elsewhere or while hidden |
| vpp_ok | input | 1 | High-voltage supply is at its correct level |
| pulse_busy | input | 1 | Pulse timer is running |
| op_start | output | 1 | One-cycle strobe that launches a pulse |
| wr_mode | output | 1 | Register open (write mode) |
| array_rd_en | output | 1 | Normal array reads permitted |
| prog_mode | output | 1 | Program operation selected |
| erase_mode | output | 1 | Erase operation selected |
| dword_mode | output | 1 | Two words per program pulse |
| bank_sel | output | 2 | Bank chosen for erase |
| pulse_sel | output | 2 | Pulse width code for the timer |

## Verification
The hardest state to reach from the ports is a sticky supply fault that must survive the end of the pulse and then be cleared by the next accepted start rather than by the fault's own removal. This state needs an armed register, a start, busy held high with the supply dropped for a cycle, and then a start attempt while busy that must be ignored. The bench drives busy and supply directly as inputs, so its vector table walks that exact order: it opens, arms, starts, raises busy, drops the supply, releases it, and then reads the register between every step. Broken key pairs and the clear-by-zero path are directed afterwards.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lk_state_e;

  // bit positions inside the register word
  localparam int B_WEN  = 0;
  localparam int B_EEN  = 1;
  localparam int B_BUSY = 2;
  localparam int B_VFLT = 3;
  localparam int B_VOK  = 4;
  localparam int B_PCK  = 5;  // two bits
  localparam int B_DW   = 7;
  localparam int B_BNK  = 8;  // two bits
  localparam int REG_MIN_W = 10;
endpackage

// File: rtl/flashctl_unlock.sv
module flashctl_unlock
  import flashctl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'h7FFE,
  parameter logic [DW-1:0] KEY = 16'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          exit_req,
  output logic          open_q
);
  localparam logic [AW-1:0] KEY_ADDR = AW'(KEY);

  lk_state_e st_q, st_d;

  logic first_hit, second_hit;
  assign first_hit  = wr_en && (addr == REG_ADDR) && (wdata == KEY);
  assign second_hit = wr_en && (addr == KEY_ADDR) && (wdata == KEY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_IDLE: if (first_hit) st_d = LK_HALF;
      LK_HALF: begin
        if (second_hit)  st_d = LK_OPEN;
        else if (wr_en)  st_d = LK_IDLE;
      end
      LK_OPEN: if (exit_req) st_d = LK_IDLE;
      default: st_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LK_IDLE;
    else        st_q <= st_d;
  end

  assign open_q = (st_q == LK_OPEN);
endmodule

// File: rtl/flashctl_cfg.sv
module flashctl_cfg
  import flashctl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int ARR_W = 15,
  parameter logic [AW-1:0] REG_ADDR = 16'h7FFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_q,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          pulse_busy,
  output logic [DW-1:0] ctl_q,
  output logic          start_hit,
  output logic          exit_req,
  output logic          op_start
);
  localparam int TAG_W = AW - ARR_W;
  localparam logic [DW-1:0] CTL_MASK =
      (DW'(1) << B_WEN) | (DW'(1) << B_EEN) | (DW'(3) << B_PCK) |
      (DW'(1) << B_DW)  | (DW'(3) << B_BNK);

  logic in_array, reg_hit;

  generate
    if (TAG_W > 0) begin : g_tag
      assign in_array = (addr[AW-1:ARR_W] == '0);
    end else begin : g_all
      assign in_array = 1'b1;
    end
  endgenerate

  assign reg_hit   = open_q && wr_en && (addr == REG_ADDR);
  assign exit_req  = reg_hit && (wdata == '0);
  assign start_hit = open_q && wr_en && in_array && (addr != REG_ADDR) &&
                     ctl_q[B_WEN] && !pulse_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      op_start <= 1'b0;
    end else begin
      op_start <= start_hit;
      if (reg_hit) ctl_q <= wdata & CTL_MASK;
    end
  end
endmodule

// File: rtl/flashctl_flag.sv
module flashctl_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_busy,
  input  logic vpp_ok,
  input  logic clr,
  output logic fault_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fault_q <= 1'b0;
    else if (pulse_busy && !vpp_ok)  fault_q <= 1'b1;
    else if (clr)                    fault_q <= 1'b0;
  end
endmodule

// File: rtl/flashctl_top.sv
module flashctl_top
  import flashctl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int ARR_W = 15,
  parameter logic [AW-1:0] REG_ADDR = 16'h7FFE,
  parameter logic [DW-1:0] KEY = 16'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          vpp_ok,
  input  logic          pulse_busy,
  output logic          op_start,
  output logic          wr_mode,
  output logic          array_rd_en,
  output logic          prog_mode,
  output logic          erase_mode,
  output logic          dword_mode,
  output logic [1:0]    bank_sel,
  output logic [1:0]    pulse_sel
);
  logic          open_q, exit_req, start_hit, fault_q;
  logic [DW-1:0] ctl_q, stat_w;

  flashctl_unlock #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR), .KEY(KEY)) u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .exit_req(exit_req), .open_q(open_q)
  );

  flashctl_cfg #(.AW(AW), .DW(DW), .ARR_W(ARR_W), .REG_ADDR(REG_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .open_q(open_q), .wr_en(bus_wr),
    .addr(bus_addr), .wdata(bus_wdata), .pulse_busy(pulse_busy),
    .ctl_q(ctl_q), .start_hit(start_hit), .exit_req(exit_req),
    .op_start(op_start)
  );

  flashctl_flag u_flag (
    .clk(clk), .rst_n(rst_n), .pulse_busy(pulse_busy), .vpp_ok(vpp_ok),
    .clr(start_hit || exit_req), .fault_q(fault_q)
  );

  always_comb begin
    stat_w         = '0;
    stat_w[B_BUSY] = pulse_busy;
    stat_w[B_VFLT] = fault_q;
    stat_w[B_VOK]  = vpp_ok;
  end

  assign bus_rdata   = (open_q && (bus_addr == REG_ADDR)) ? (ctl_q | stat_w) : '0;
  assign wr_mode     = open_q;
  assign array_rd_en = !open_q;
  assign prog_mode   = ctl_q[B_WEN] && !ctl_q[B_EEN];
  assign erase_mode  = ctl_q[B_WEN] && ctl_q[B_EEN];
  assign dword_mode  = ctl_q[B_DW];
  assign bank_sel    = ctl_q[B_BNK +: 2];
  assign pulse_sel   = ctl_q[B_PCK +: 2];
endmodule

// File: rtl/flashctl_chk.sv
module flashctl_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'h7FFE,
  parameter logic [DW-1:0] KEY = 16'h1000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          pulse_busy,
  input logic          vpp_ok,
  input logic          open_q,
  input logic          fault_q,
  input logic          op_start,
  input logic [DW-1:0] rdata
);
  p_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |-> (rdata == '0));

  p_key_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_q) |-> $past(wr_en && (addr == AW'(KEY)) && (wdata == KEY)));

  p_start_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(open_q));

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> !$past(pulse_busy));

  p_fault_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_busy && !vpp_ok) |=> fault_q);

  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !wr_en) |=> fault_q);

  p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && wr_en && (addr == REG_ADDR) && (wdata == '0)) |=> !open_q);

  p_reg_nostart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == REG_ADDR)) |=> !op_start);
endmodule

bind flashctl_top flashctl_chk #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
  .pulse_busy(pulse_busy), .vpp_ok(vpp_ok), .open_q(open_q), .fault_q(fault_q),
  .op_start(op_start), .rdata(bus_rdata)
);

// File: tb/test_flashctl_top.sv
`timescale 1ns/1ps
module test_flashctl_top;
  localparam logic [15:0] RA = 16'h7FFE;
  localparam logic [15:0] KY = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        vpp_ok = 1'b1, pulse_busy = 1'b0;
  logic        op_start, wr_mode, array_rd_en, prog_mode, erase_mode, dword_mode;
  logic [1:0]  bank_sel, pulse_sel;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  flashctl_top i_flashctl_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vpp_ok(vpp_ok),
    .pulse_busy(pulse_busy), .op_start(op_start), .wr_mode(wr_mode),
    .array_rd_en(array_rd_en), .prog_mode(prog_mode), .erase_mode(erase_mode),
    .dword_mode(dword_mode), .bank_sel(bank_sel), .pulse_sel(pulse_sel)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic        busy;
    logic        vpp;
    logic        e_start;
    logic        e_rden;
    logic [15:0] e_rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t TBL [0:NV-1] = '{
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd1},  // R1 hidden
    '{1'b1, RA,       KY,       1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd2},  // R2 key step 1
    '{1'b1, KY,       KY,       1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2 key step 2
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0010, 4'd5},  // R5 supply bit
    '{1'b1, RA,       16'h0081, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0091, 4'd6},  // R6 arm only
    '{1'b1, 16'h000C, 16'h8642, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd6},  // R6 start
    '{1'b0, RA,       16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0095, 4'd5},  // R5 busy bit
    '{1'b1, 16'h000C, 16'h8642, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7 ignored
    '{1'b0, RA,       16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h008D, 4'd8},  // R8 fault set
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0099, 4'd8},  // R8 fault held
    '{1'b1, 16'h000E, 16'h9753, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd8},  // R8 start clears
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0091, 4'd8},  // R8 cleared
    '{1'b1, RA,       16'h0362, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0372, 4'd4},  // R4 fields
    '{1'b1, 16'h0100, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10 no enable
    '{1'b1, RA,       16'h0343, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0353, 4'd11}, // R11 reg write
    '{1'b1, 16'h2000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000, 4'd6},  // R6 erase start
    '{1'b1, RA,       16'hFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 16'h03F3, 4'd4},  // R4 masking
    '{1'b1, 16'h8000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd6},  // R6 outside array
    '{1'b1, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd9},  // R9 exit
    '{1'b1, 16'h0004, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd9},  // R9 no start
    '{1'b1, RA,       KY,       1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 step 1
    '{1'b1, 16'h0002, 16'h1234, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 intruder
    '{1'b1, KY,       KY,       1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 stays shut
    '{1'b1, RA,       16'h1001, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 bad key
    '{1'b1, KY,       KY,       1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 stays shut
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd3},  // R3 hidden
    '{1'b1, RA,       KY,       1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd2},  // R2 again
    '{1'b1, KY,       KY,       1'b0, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd2},  // R2 open
    '{1'b0, RA,       16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0010, 4'd9}   // R9 ctl cleared
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one cycle: drive at falling edge, clock, sample at next falling edge
  task automatic step(input logic wr, input logic [15:0] a, input logic [15:0] d,
                      input logic busy, input logic vpp);
    bus_wr = wr; bus_addr = a; bus_wdata = d; pulse_busy = busy; vpp_ok = vpp;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rden", int'(array_rd_en), 1);
    check("R1 start", int'(op_start), 0);
    check("R1 modes", int'({prog_mode, erase_mode, dword_mode, bank_sel, pulse_sel}), 0);

    for (int i = 0; i < NV; i++) begin
      step(TBL[i].wr, TBL[i].addr, TBL[i].wdata, TBL[i].busy, TBL[i].vpp);
      check($sformatf("R%0d row%0d start", TBL[i].req, i), int'(op_start), int'(TBL[i].e_start));
      check($sformatf("R%0d row%0d rden", TBL[i].req, i), int'(array_rd_en), int'(TBL[i].e_rden));
      check($sformatf("R%0d row%0d rdata", TBL[i].req, i), int'(bus_rdata), int'(TBL[i].e_rdata));
    end

    // R4 mode outputs, erase setup
    step(1'b1, RA, 16'h0343, 1'b0, 1'b1);
    check("R4 erase", int'({prog_mode, erase_mode, dword_mode}), 3'b010);
    check("R4 bank", int'(bank_sel), 3);
    check("R4 pulse", int'(pulse_sel), 2);
    // R4 program, two words
    step(1'b1, RA, 16'h00A1, 1'b0, 1'b1);
    check("R4 prog", int'({prog_mode, erase_mode, dword_mode}), 3'b101);
    check("R4 bank0", int'(bank_sel), 0);
    check("R4 pulse1", int'(pulse_sel), 1);

    // R9 fault cleared by the zero write
    step(1'b0, RA, 16'h0000, 1'b1, 1'b0);
    step(1'b0, RA, 16'h0000, 1'b0, 1'b1);
    check("R8 pre-exit", int'(bus_rdata), 16'h00B9);
    step(1'b1, RA, 16'h0000, 1'b0, 1'b1);
    check("R9 modes", int'({prog_mode, erase_mode, dword_mode, bank_sel, pulse_sel}), 0);
    step(1'b1, RA, KY, 1'b0, 1'b1);
    // R3 array write between key steps breaks the pair
    step(1'b1, 16'h0040, 16'h0000, 1'b0, 1'b1);
    check("R3 no start half", int'(op_start), 0);
    step(1'b1, KY, KY, 1'b0, 1'b1);
    check("R3 still shut", int'(wr_mode), 0);
    step(1'b1, RA, KY, 1'b0, 1'b1);
    step(1'b1, KY, KY, 1'b0, 1'b1);
    step(1'b0, RA, 16'h0000, 1'b0, 1'b1);
    check("R9 fault gone", int'(bus_rdata), 16'h0010);

    // R1 reset while open and armed
    step(1'b1, RA, 16'h0081, 1'b0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst rden", int'(array_rd_en), 1);
    check("R1 rst rdata", int'(bus_rdata), 0);
    check("R1 rst modes", int'({prog_mode, dword_mode}), 0);

    finish_run();
  end
endmodule